// File: doc/BRIEF.md
# I2C master write controller

This block is a bus master for a two-wire serial bus that only ever writes. Software picks a 7-bit target address and, when the target needs one, a single register-offset byte. It then feeds payload bytes one at a time through a one-entry holding register. The first byte written while the bus is quiet opens a transfer. The controller sends a START, the address with a cleared direction bit, the optional offset byte, and then each payload byte. After every byte it checks for an acknowledge.

No length is ever programmed. A payload byte moves into the shifter only when the byte before it has been acknowledged. If the holding register is empty at that moment, the controller closes the bus with a STOP. A refused byte (NACK) also ends the transfer with a STOP. Three flags report progress: holding-register empty, transfer done and NACK seen. Each flag can be routed to a single interrupt line through an enable mask.

Both wires are open-drain. The block only ever pulls a line low or lets it float. It reads the resolved data line through a configurable synchroniser. The clock line runs from a fixed divider, with equal low and high halves.

Top module: `i2c_wr_master`

## Requirements
- R1: After reset, and whenever no transfer is running, neither line is pulled low. After reset the flags read holding-empty = 1, done = 1, nack = 0, and irq = 0.
- R2: Writing select 2 (holding register) while idle starts a transfer. The transfer opens with a START (data falls while the clock is high), followed by the byte {address[6:0], 0} sent most significant bit first. Done reads 0 from the cycle after the START is launched.
- R3: When bit 7 of the select-0 register is 1, the byte held at select 1 goes out after the address byte and before any payload byte. Bits 6:0 of the select-0 register hold the address.
- R4: A holding-register write clears holding-empty on the next cycle. Payload bytes leave the holding register only after the preceding byte is acknowledged, and they reach the bus in the order they were written. Holding-empty returns to 1 when a byte is taken.
- R5: If a byte is acknowledged while the holding register is empty, the block sends a STOP and sets done. No extra byte is sent.
- R6: If the data line is high during an acknowledge clock, the block sends a STOP and sets nack. It discards any byte in the holding register, which sets holding-empty, and sets done once the STOP is out.
- R7: The nack flag reads 0 from the cycle after the next START is launched.
- R8: The select-3 register bits [0], [1] and [2] enable holding-empty, done and nack onto irq. irq is high exactly when an enabled flag is set.
- R9: Each clock-high phase of a data or acknowledge bit lasts 2*QTR_CYC system clocks, the same as its low phase.
- R10: Within a transfer, the data line changes only while the clock is low. The only exceptions are exactly one START and one STOP per transfer.
- R11: During the high phase of every acknowledge clock, the block does not pull the data line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address/options, 1 offset byte, 2 holding, 3 irq enables |
| cfg_wdata | input | 8 | Register write data |
| sda_in | input | 1 | Resolved data-line level |
| scl_drive_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls the data line low, 0 releases it |
| st_hold_empty | output | 1 | Holding register empty (transmit ready) |
| st_done | output | 1 | Transfer complete |
| st_nack | output | 1 | Last transfer ended on a refused byte |
| irq | output | 1 | Masked interrupt |

## Verification
The bench includes a byte-collecting target model on the resolved lines. It runs transfers of one to four payload bytes, with and without the offset byte, and with byte values that cover all-ones, all-zeros and alternating patterns. Comparing byte order separates the holding-to-shifter hand-off from lost or repeated bytes. The single-byte runs tell the automatic STOP apart from a miscounted length. The target refuses the address byte in one run and a payload byte in another, which tests STOP after a NACK and the discarding of a queued byte. On every clock, the model also measures clock-high widths, counts START and STOP events, and watches the data line during acknowledge clocks.

// File: rtl/i2c_wm_pkg.sv
`timescale 1ns/1ps
package i2c_wm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_START,
      ST_BYTE,
      ST_STOP
   } seq_state_e;

   typedef enum logic [1:0] {
      BK_ADDR,
      BK_IADR,
      BK_DATA
   } byte_kind_e;

   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_IADR = 2'd1;
   localparam logic [1:0] SEL_HOLD = 2'd2;
   localparam logic [1:0] SEL_IEN  = 2'd3;

   localparam int FLAG_W   = 3;
   localparam int BYTE_W   = 8;
   localparam int DEV_W    = 7;
   localparam int ACK_SLOT = 8;

endpackage

// File: rtl/i2c_wm_sync.sv
`timescale 1ns/1ps
module i2c_wm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         for (genvar i = 0; i < STAGES; i++) begin : g_st
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) ff[i] <= 1'b1;
                  else        ff[i] <= d_in;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) ff[i] <= 1'b1;
                  else        ff[i] <= ff[i-1];
               end
            end
         end
         assign d_out = ff[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/i2c_wm_regs.sv
`timescale 1ns/1ps
module i2c_wm_regs
   import i2c_wm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        sel,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              start_pulse,
   input  logic              take_pulse,
   input  logic              nack_pulse,
   input  logic              done_pulse,
   output logic [DEV_W-1:0]  dev_addr,
   output logic              iadr_en,
   output logic [BYTE_W-1:0] iadr,
   output logic [BYTE_W-1:0] hold_data,
   output logic              hold_full,
   output logic              st_hold_empty,
   output logic              st_done,
   output logic              st_nack,
   output logic              irq
);

   logic [BYTE_W-1:0] ctrl_q, iadr_q, hold_q;
   logic [FLAG_W-1:0] ien_q;
   logic              full_q, done_q, nack_q;
   logic              hold_wr;

   assign hold_wr = we && (sel == SEL_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         iadr_q <= '0;
         hold_q <= '0;
         ien_q  <= '0;
         full_q <= 1'b0;
         done_q <= 1'b1;
         nack_q <= 1'b0;
      end else begin
         if (we && sel == SEL_CTRL) ctrl_q <= wdata;
         if (we && sel == SEL_IADR) iadr_q <= wdata;
         if (we && sel == SEL_IEN)  ien_q  <= wdata[FLAG_W-1:0];
         // a fresh write wins over a same-cycle take or discard
         if (hold_wr) begin
            hold_q <= wdata;
            full_q <= 1'b1;
         end else if (take_pulse || nack_pulse) begin
            full_q <= 1'b0;
         end
         if (start_pulse)     done_q <= 1'b0;
         else if (done_pulse) done_q <= 1'b1;
         if (start_pulse)     nack_q <= 1'b0;
         else if (nack_pulse) nack_q <= 1'b1;
      end
   end

   assign dev_addr      = ctrl_q[DEV_W-1:0];
   assign iadr_en       = ctrl_q[BYTE_W-1];
   assign iadr          = iadr_q;
   assign hold_data     = hold_q;
   assign hold_full     = full_q;
   assign st_hold_empty = ~full_q;
   assign st_done       = done_q;
   assign st_nack       = nack_q;
   assign irq           = |(ien_q & {nack_q, done_q, ~full_q});

   // R4: holding-empty only falls after a holding write
   assert_hold_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st_hold_empty) |-> $past(hold_wr));

   // R2: launching a START clears done
   assert_done_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !st_done);

   // R6: a refused byte empties the holding register and raises nack
   assert_nack_discard_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (nack_pulse && !hold_wr) |=> (st_hold_empty && st_nack));

endmodule

// File: rtl/i2c_wm_seq.sv
`timescale 1ns/1ps
module i2c_wm_seq
   import i2c_wm_pkg::*;
#(
   parameter int QTR_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DEV_W-1:0]  dev_addr,
   input  logic              iadr_en,
   input  logic [BYTE_W-1:0] iadr,
   input  logic [BYTE_W-1:0] hold_data,
   input  logic              hold_full,
   input  logic              sda_s,
   output logic              start_pulse,
   output logic              take_pulse,
   output logic              nack_pulse,
   output logic              done_pulse,
   output logic              scl_drive_low,
   output logic              sda_drive_low
);

   localparam int CNT_W = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QTR_CYC - 1);
   localparam logic [3:0] ACK_IDX = 4'(ACK_SLOT);

   seq_state_e        st_q;
   byte_kind_e        kind_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [1:0]        qph_q;
   logic [3:0]        bitn_q;
   logic [BYTE_W-1:0] sh_q;
   logic              ack_hi_q, sda_drv_q;

   logic tick, last_q, ack_end, want_iadr, bit_want;

   assign tick      = (st_q != ST_IDLE) && (cnt_q == CNT_LAST);
   assign last_q    = tick && (qph_q == 2'd3);
   assign ack_end   = last_q && (st_q == ST_BYTE) && (bitn_q == ACK_IDX);
   assign want_iadr = (kind_q == BK_ADDR) && iadr_en;
   assign bit_want  = (bitn_q == ACK_IDX) ? 1'b0 : ~sh_q[BYTE_W-1];

   assign start_pulse = (st_q == ST_IDLE) && hold_full;
   assign nack_pulse  = ack_end && ack_hi_q;
   assign take_pulse  = ack_end && !ack_hi_q && !want_iadr && hold_full;
   assign done_pulse  = last_q && (st_q == ST_STOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         kind_q    <= BK_ADDR;
         cnt_q     <= '0;
         qph_q     <= '0;
         bitn_q    <= '0;
         sh_q      <= '0;
         ack_hi_q  <= 1'b0;
         sda_drv_q <= 1'b0;
      end else if (st_q == ST_IDLE) begin
         cnt_q     <= '0;
         qph_q     <= '0;
         sda_drv_q <= 1'b0;
         if (hold_full) st_q <= ST_START;
      end else begin
         cnt_q <= tick ? '0 : cnt_q + 1'b1;
         if (tick) qph_q <= qph_q + 2'd1;
         // data line moves one quarter after the clock falls
         if (tick && qph_q == 2'd0) begin
            case (st_q)
               ST_START: sda_drv_q <= 1'b1;
               ST_BYTE:  sda_drv_q <= bit_want;
               ST_STOP:  sda_drv_q <= 1'b1;
               default:  sda_drv_q <= 1'b0;
            endcase
         end
         if (tick && qph_q == 2'd2 && st_q == ST_STOP) sda_drv_q <= 1'b0;
         if (tick && qph_q == 2'd2 && st_q == ST_BYTE && bitn_q == ACK_IDX)
            ack_hi_q <= sda_s;
         if (last_q) begin
            case (st_q)
               ST_START: begin
                  st_q   <= ST_BYTE;
                  bitn_q <= '0;
                  sh_q   <= {dev_addr, 1'b0};
                  kind_q <= BK_ADDR;
               end
               ST_BYTE: begin
                  if (bitn_q != ACK_IDX) begin
                     bitn_q <= bitn_q + 4'd1;
                     sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
                  end else if (ack_hi_q) begin
                     st_q <= ST_STOP;
                  end else if (want_iadr) begin
                     sh_q   <= iadr;
                     kind_q <= BK_IADR;
                     bitn_q <= '0;
                  end else if (hold_full) begin
                     sh_q   <= hold_data;
                     kind_q <= BK_DATA;
                     bitn_q <= '0;
                  end else begin
                     st_q <= ST_STOP;
                  end
               end
               ST_STOP: st_q <= ST_IDLE;
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      case (st_q)
         ST_START: scl_drive_low = (qph_q == 2'd3);
         ST_BYTE:  scl_drive_low = (qph_q < 2'd2);
         ST_STOP:  scl_drive_low = (qph_q < 2'd2);
         default:  scl_drive_low = 1'b0;
      endcase
   end

   assign sda_drive_low = sda_drv_q;

   // R10: inside a byte the data line holds while the clock is released
   assert_sda_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BYTE && $past(st_q) == ST_BYTE && !scl_drive_low && !$past(scl_drive_low))
      |-> $stable(sda_drive_low));

   // R11: master lets go of the data line in the acknowledge slot
   assert_ack_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BYTE && bitn_q == ACK_IDX && qph_q != 2'd0) |-> !sda_drive_low);

   // R1: a quiet bus is never pulled
   assert_idle_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> (!scl_drive_low && !sda_drive_low));

   // R4: only a filled holding register is consumed
   assert_take_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      take_pulse |-> hold_full);

   // R6: a refusal is followed by the STOP sequence
   assert_nack_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      nack_pulse |=> (st_q == ST_STOP));

endmodule

// File: rtl/i2c_wr_master.sv
`timescale 1ns/1ps
module i2c_wr_master
   import i2c_wm_pkg::*;
#(
   parameter int QTR_CYC     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic [1:0] cfg_sel,
   input  logic [7:0] cfg_wdata,
   input  logic       sda_in,
   output logic       scl_drive_low,
   output logic       sda_drive_low,
   output logic       st_hold_empty,
   output logic       st_done,
   output logic       st_nack,
   output logic       irq
);

   generate
      if (QTR_CYC < 2) begin : g_bad_qtr
         $error("QTR_CYC must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES >= QTR_CYC) begin : g_bad_sync
         $error("SYNC_STAGES must be non-negative and below QTR_CYC");
      end
   endgenerate

   logic [DEV_W-1:0]  dev_addr;
   logic [BYTE_W-1:0] iadr, hold_data;
   logic              iadr_en, hold_full, sda_s;
   logic              start_pulse, take_pulse, nack_pulse, done_pulse;

   i2c_wm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (sda_in),
      .d_out (sda_s)
   );

   i2c_wm_regs u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .we            (cfg_we),
      .sel           (cfg_sel),
      .wdata         (cfg_wdata),
      .start_pulse   (start_pulse),
      .take_pulse    (take_pulse),
      .nack_pulse    (nack_pulse),
      .done_pulse    (done_pulse),
      .dev_addr      (dev_addr),
      .iadr_en       (iadr_en),
      .iadr          (iadr),
      .hold_data     (hold_data),
      .hold_full     (hold_full),
      .st_hold_empty (st_hold_empty),
      .st_done       (st_done),
      .st_nack       (st_nack),
      .irq           (irq)
   );

   i2c_wm_seq #(.QTR_CYC(QTR_CYC)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .dev_addr      (dev_addr),
      .iadr_en       (iadr_en),
      .iadr          (iadr),
      .hold_data     (hold_data),
      .hold_full     (hold_full),
      .sda_s         (sda_s),
      .start_pulse   (start_pulse),
      .take_pulse    (take_pulse),
      .nack_pulse    (nack_pulse),
      .done_pulse    (done_pulse),
      .scl_drive_low (scl_drive_low),
      .sda_drive_low (sda_drive_low)
   );

endmodule

// File: tb/i2c_wr_master_tb_top.sv
`timescale 1ns/1ps
module i2c_wr_master_tb_top;

   localparam int QTR = 4;
   localparam logic [1:0] S_CTRL = 2'd0, S_IADR = 2'd1, S_HOLD = 2'd2, S_IEN = 2'd3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_sel = 2'd0;
   logic [7:0] cfg_wdata = 8'd0;
   logic       scl_dl, sda_dl, st_hold_empty, st_done, st_nack, irq;
   logic       s_drive = 1'b0;
   logic       sda_line;

   assign sda_line = !(sda_dl | s_drive);

   always #10 clk = ~clk;   // 50 MHz

   i2c_wr_master #(.QTR_CYC(QTR), .SYNC_STAGES(2)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_we        (cfg_we),
      .cfg_sel       (cfg_sel),
      .cfg_wdata     (cfg_wdata),
      .sda_in        (sda_line),
      .scl_drive_low (scl_dl),
      .sda_drive_low (sda_dl),
      .st_hold_empty (st_hold_empty),
      .st_done       (st_done),
      .st_nack       (st_nack),
      .irq           (irq)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // ---------------- target model, sampled every clock ----------------
   logic [7:0] rxq[$];
   logic [7:0] s_byte = 8'd0;
   int  s_cnt = 0, nack_at = -1;
   int  n_start = 0, n_stop = 0, hi_len = 0, hi_bad = 0, rel_bad = 0;
   bit  skip_hi = 1'b1, p_scl = 1'b1, p_sda = 1'b1;

   always @(negedge clk) begin
      bit scl_l, sda_l;
      if (rst_n) begin
         scl_l = !scl_dl;
         sda_l = sda_line;
         if (p_scl && scl_l && p_sda && !sda_l) begin
            n_start++; s_cnt = 0; skip_hi = 1'b1;
         end else if (p_scl && scl_l && !p_sda && sda_l) begin
            n_stop++; s_cnt = 0;
         end
         if (!p_scl && scl_l) begin
            hi_len = 0;
            if (s_cnt < 8) begin
               s_byte = {s_byte[6:0], sda_l};
               s_cnt++;
               if (s_cnt == 8) rxq.push_back(s_byte);
            end else if (s_cnt == 8) begin
               s_cnt = 9;
            end
         end
         if (p_scl && !scl_l) begin
            if (!skip_hi && hi_len != 2*QTR) hi_bad++;   // R9
            skip_hi = 1'b0;
            if (s_cnt == 8) s_drive = ((rxq.size() - 1) != nack_at);
            else if (s_cnt == 9) begin s_drive = 1'b0; s_cnt = 0; end
         end
         if (scl_l) hi_len++;
         if (s_cnt == 9 && scl_l && sda_dl) rel_bad++;   // R11
         p_scl = scl_l;
         p_sda = sda_l;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic reg_write(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   logic [7:0] dq[$];

   task automatic xfer(input logic [6:0] dev, input bit use_ia, input logic [7:0] ia,
                       input int nk);
      logic [7:0] exp[$];
      rxq.delete();
      n_start = 0; n_stop = 0; hi_bad = 0; rel_bad = 0;
      nack_at = nk;
      reg_write(S_CTRL, {use_ia, dev});
      reg_write(S_IADR, ia);
      reg_write(S_HOLD, dq[0]);
      check(st_hold_empty == 1'b0, "R4", "holding-empty after write", st_hold_empty, 0);
      @(negedge clk);
      check(st_done == 1'b0, "R2", "done cleared at START", st_done, 0);
      check(st_nack == 1'b0, "R7", "nack cleared at START", st_nack, 0);
      for (int i = 1; i < dq.size(); i++) begin
         while (!st_hold_empty && !st_nack) @(negedge clk);
         if (st_nack) break;
         reg_write(S_HOLD, dq[i]);
      end
      while (!st_done) @(negedge clk);
      @(negedge clk);
      exp.push_back({dev, 1'b0});
      if (use_ia) exp.push_back(ia);
      foreach (dq[i]) exp.push_back(dq[i]);
      if (nk >= 0) while (exp.size() > nk + 1) void'(exp.pop_back());
      check(rxq.size() == exp.size(), "R5", "bytes on bus", rxq.size(), exp.size());
      for (int i = 0; i < exp.size() && i < rxq.size(); i++) begin
         if (i == 0)                  check(rxq[i] == exp[i], "R2", "address byte", rxq[i], exp[i]);
         else if (use_ia && i == 1)   check(rxq[i] == exp[i], "R3", "offset byte", rxq[i], exp[i]);
         else                         check(rxq[i] == exp[i], "R4", "payload byte", rxq[i], exp[i]);
      end
      check(n_start == 1, "R10", "START count", n_start, 1);
      check(n_stop == 1, "R10", "STOP count", n_stop, 1);
      check(hi_bad == 0, "R9", "clock-high width errors", hi_bad, 0);
      check(rel_bad == 0, "R11", "data pulled in ack slot", rel_bad, 0);
      check(st_done == 1'b1, "R5", "done after STOP", st_done, 1);
      check(st_hold_empty == 1'b1, "R6", "holding empty at end", st_hold_empty, 1);
      check(st_nack == (nk >= 0), "R6", "nack flag", st_nack, int'(nk >= 0));
      check(!scl_dl && !sda_dl, "R1", "lines free after transfer", {scl_dl, sda_dl}, 0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not finish actual=expired expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!scl_dl && !sda_dl, "R1", "lines after reset", {scl_dl, sda_dl}, 0);
      check(st_hold_empty == 1'b1, "R1", "holding-empty after reset", st_hold_empty, 1);
      check(st_done == 1'b1, "R1", "done after reset", st_done, 1);
      check(st_nack == 1'b0, "R1", "nack after reset", st_nack, 0);
      check(irq == 1'b0, "R1", "irq after reset", irq, 0);

      reg_write(S_IEN, 8'h01);
      check(irq == 1'b1, "R8", "irq from holding-empty", irq, 1);
      reg_write(S_IEN, 8'h00);
      check(irq == 1'b0, "R8", "irq masked", irq, 0);

      dq = '{8'hA5};
      xfer(7'h50, 1'b0, 8'h00, -1);

      dq = '{8'h11, 8'h22, 8'hC3};
      xfer(7'h2D, 1'b1, 8'h3C, -1);

      reg_write(S_IEN, 8'h02);
      check(irq == 1'b1, "R8", "irq from done", irq, 1);
      reg_write(S_IEN, 8'h04);
      check(irq == 1'b0, "R8", "nack enable with nack clear", irq, 0);

      dq = '{8'h01, 8'h02};
      xfer(7'h7F, 1'b0, 8'h00, 0);
      check(irq == 1'b1, "R8", "irq from nack", irq, 1);
      reg_write(S_IEN, 8'h00);

      dq = '{8'hAA, 8'h55, 8'hF0};
      xfer(7'h12, 1'b1, 8'h80, 2);

      dq = '{8'hFF, 8'h00, 8'h80, 8'h7E};
      xfer(7'h01, 1'b0, 8'h00, -1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule